// File: doc/BRIEF.md
# Banked Programmable Clock Output Controller

This block sits behind a frequency synthesizer. It divides a fast source clock, which stands in for the oscillator, down to a complementary output pair. The divide ratio comes from one of two configuration banks. Each bank holds a 5-bit post-divide value and an option bit for the auxiliary clock. Bank contents are loaded through a single-cycle register write port.

One shared pin takes on one of three roles. The role is fixed once, on the first source-clock edge after reset is released. In the first role the pin is a level input that enables the output drivers. In the second it is a level input that chooses the active bank. In the third it is an output that carries the reference clock, either at full rate or halved.

The shared pin is modelled as separate wires: an input level, a flag saying whether anything drives it, an output value and an output enable. A pin that nothing drives reads high. New bank contents, and a change of bank, are applied only where one output period ends and the next begins. Both halves of every period therefore stay the same length.

Top module: `bank_clk_out`

## Requirements
- R1: `clkOutP` has a period of 2*P source-clock cycles for a bank value P in 1..31, with P cycles low followed by P cycles high; no half ever lasts more than 31 cycles.
- R2: A bank value P of 0 behaves exactly as P = 1, giving a period of 2 cycles.
- R3: `clkOutN` is the logical complement of `clkOutP` in every cycle.
- R4: While `rstN` is low, `clkOutP` is 0, `clkOutN` is 1 and `pinOutEn` is 0. Both banks reset to P = 4 with the auxiliary option cleared, so the first periods after release last 8 cycles.
- R5: A write with `wrEn` = 1 stores `wrData[4:0]` as P and `wrData[5]` as the auxiliary-halving option into the bank chosen by `wrBank`. Stored values take effect at the next falling edge of `clkOutP`, which is where a period ends.
- R6: When `pinModeCfg` is 1 (bank select), an effective pin level of 0 selects bank 0 and a level of 1 selects bank 1. A change of bank is applied only at a period end, so the high half of every period equals its preceding low half.
- R7: When `pinModeCfg` is 0 or 3 (enable), an effective pin level of 0 drives `clkOutEn` to 0 within 3 cycles and a level of 1 drives it to 1. The divider keeps running and bank 0 stays in use.
- R8: With `pinDrv` = 0 the effective pin level is 1, whatever `pinIn` holds.
- R9: When `pinModeCfg` is 2 (auxiliary clock), `pinOutEn` is 1, `clkOutEn` stays 1 and bank 0 is used. `pinOut` follows `refClk` when the bank-0 option bit is 0 and toggles on each `refClk` rising edge when that bit is 1. In the other modes `pinOutEn` is 0.
- R10: The pin role is captured on the first source-clock edge after reset release; later changes on `pinModeCfg` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock that is divided down |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Reference clock for the auxiliary output |
| pinModeCfg | input | 2 | Shared-pin role: 0 enable, 1 bank select, 2 auxiliary clock, 3 enable |
| pinIn | input | 1 | Level applied to the shared pin from outside |
| pinDrv | input | 1 | 1 when something outside drives the shared pin |
| wrEn | input | 1 | Bank write strobe |
| wrBank | input | 1 | Bank addressed by the write |
| wrData | input | 6 | Bits 4:0 hold the P value, bit 5 holds the auxiliary-halving option |
| clkOutP | output | 1 | Main divided clock |
| clkOutN | output | 1 | Complement of `clkOutP` |
| clkOutEn | output | 1 | Driver enable of the main pair; 0 means tri-stated |
| pinOut | output | 1 | Value the shared pin drives in auxiliary mode |
| pinOutEn | output | 1 | 1 when the shared pin is driven by the block |

## Verification
The bench measures every output period between rising edges and compares it with a queue of expected lengths. It covers P = 0, P = 31, writes made while a bank is active, and bank swaps made from mid-period. A design that switched banks at once would leave a mixed or runt period, and the half-length assertion would fire. A design that passed P = 0 straight through would stall at a count that never matches. The bench also changes the role input after reset: a design that decoded the role live would tri-state the pair or swap banks where it must not. An undriven pin is left to float in both input roles, and a design without the pull-up would pick the wrong bank or disable the drivers. In auxiliary mode the pin output is sampled against the reference edges, which tells a pass-through apart from a halved clock.

// File: rtl/bank_clk_pkg.sv
package bank_clk_pkg;

  // Role of the shared pin, captured once after reset
  typedef enum logic [1:0] {
    PM_ENABLE  = 2'd0,
    PM_BANKSEL = 2'd1,
    PM_AUXCLK  = 2'd2,
    PM_RSVD    = 2'd3
  } pinModeT;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic outEn;    // main drivers enabled
    logic bankReq;  // bank wanted for the next period
    logic auxMode;  // shared pin acts as a clock output
  } ctlStrobeT;

endpackage

// File: rtl/bank_clk_ctl.sv
module bank_clk_ctl
  import bank_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pinModeCfg,
  input  logic       pinIn,
  input  logic       pinDrv,
  output ctlStrobeT  strobe
);

  // Undriven pin reads high (pull-up)
  logic pinLevel;
  assign pinLevel = pinDrv ? pinIn : 1'b1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinLevel};
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // Role captured on the first edge after reset release
  pinModeT modeQ;
  logic    armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= PM_ENABLE;
      armed <= 1'b0;
    end else if (!armed) begin
      modeQ <= pinModeT'(pinModeCfg);
      armed <= 1'b1;
    end
  end

  always_comb begin
    strobe.outEn   = 1'b1;
    strobe.bankReq = 1'b0;
    strobe.auxMode = 1'b0;
    unique case (modeQ)
      PM_BANKSEL: strobe.bankReq = pinSync;
      PM_AUXCLK:  strobe.auxMode = 1'b1;
      default:    strobe.outEn   = pinSync;
    endcase
  end

endmodule

// File: rtl/bank_clk_div.sv
module bank_clk_div
  import bank_clk_pkg::*;
#(
  parameter int P_W     = 5,
  parameter int DEF_P0  = 4,
  parameter int DEF_P1  = 4,
  parameter bit DEF_AUX = 1'b0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic           wrBank,
  input  logic [P_W:0]   wrData,
  input  ctlStrobeT      strobe,
  output logic           clkP,
  output logic           clkN,
  output logic           clkEn,
  output logic           auxHalf
);

  localparam int NBANK = 2;
  localparam logic [P_W-1:0] INIT_P0 = P_W'(DEF_P0);
  localparam logic [P_W-1:0] INIT_P1 = P_W'(DEF_P1);
  localparam logic [P_W-1:0] START_P = (INIT_P0 == '0) ? P_W'(1) : INIT_P0;

  logic [NBANK-1:0][P_W-1:0] bankP;
  logic [NBANK-1:0]          bankAux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankP[0] <= INIT_P0;
      bankP[1] <= INIT_P1;
      bankAux  <= {NBANK{DEF_AUX}};
    end else if (wrEn) begin
      for (int b = 0; b < NBANK; b++) begin
        if (wrBank == b[0]) begin
          bankP[b]   <= wrData[P_W-1:0];
          bankAux[b] <= wrData[P_W];
        end
      end
    end
  end

  // A zero divide value is run as one
  function automatic logic [P_W-1:0] effP(input logic [P_W-1:0] v);
    return (v == '0) ? P_W'(1) : v;
  endfunction

  logic [P_W-1:0] cnt, curP;
  logic           phase, curAux, halfDone;

  assign halfDone = (cnt == curP - P_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      phase  <= 1'b0;
      curP   <= START_P;
      curAux <= DEF_AUX;
    end else if (halfDone) begin
      cnt   <= '0;
      phase <= ~phase;
      if (phase) begin
        // period boundary: take the new bank and contents
        curP   <= effP(bankP[strobe.bankReq]);
        curAux <= bankAux[strobe.bankReq];
      end
    end else begin
      cnt <= cnt + P_W'(1);
    end
  end

  assign clkP    = phase;
  assign clkN    = ~phase;
  assign clkEn   = strobe.outEn;
  assign auxHalf = curAux;

endmodule

// File: rtl/bank_clk_aux.sv
module bank_clk_aux (
  input  logic refClk,
  input  logic rstN,
  input  logic auxMode,
  input  logic auxHalf,
  output logic pinOut,
  output logic pinOutEn
);

  logic refHalf;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) refHalf <= 1'b0;
    else       refHalf <= ~refHalf;
  end

  assign pinOut   = auxMode & (auxHalf ? refHalf : refClk);
  assign pinOutEn = auxMode;

endmodule

// File: rtl/bank_clk_out.sv
module bank_clk_out
  import bank_clk_pkg::*;
#(
  parameter int P_W         = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_P0      = 4,
  parameter int DEF_P1      = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refClk,
  input  logic [1:0]   pinModeCfg,
  input  logic         pinIn,
  input  logic         pinDrv,
  input  logic         wrEn,
  input  logic         wrBank,
  input  logic [P_W:0] wrData,
  output logic         clkOutP,
  output logic         clkOutN,
  output logic         clkOutEn,
  output logic         pinOut,
  output logic         pinOutEn
);

  ctlStrobeT strobe;
  logic      auxHalf;

  bank_clk_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .pinModeCfg(pinModeCfg),
    .pinIn(pinIn), .pinDrv(pinDrv), .strobe(strobe)
  );

  bank_clk_div #(.P_W(P_W), .DEF_P0(DEF_P0), .DEF_P1(DEF_P1), .DEF_AUX(1'b0)) u_div (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank), .wrData(wrData),
    .strobe(strobe), .clkP(clkOutP), .clkN(clkOutN), .clkEn(clkOutEn),
    .auxHalf(auxHalf)
  );

  bank_clk_aux u_aux (
    .refClk(refClk), .rstN(rstN), .auxMode(strobe.auxMode),
    .auxHalf(auxHalf), .pinOut(pinOut), .pinOutEn(pinOutEn)
  );

endmodule

// File: rtl/bank_clk_out_chk.sv
module bank_clk_out_chk #(
  parameter int P_W = 5
) (
  input logic clk,
  input logic rstN,
  input logic clkOutP,
  input logic clkOutN,
  input logic clkOutEn,
  input logic pinOutEn
);

  localparam int LW = P_W + 2;
  localparam logic [LW-1:0] MAXH = LW'((1 << P_W) - 1);

  logic          prevP;
  logic [LW-1:0] runLen, lowLen;

  // Length of the current level run and of the last low run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevP  <= 1'b0;
      runLen <= '0;
      lowLen <= '0;
    end else begin
      prevP <= clkOutP;
      if (clkOutP == prevP) begin
        if (runLen != '1) runLen <= runLen + LW'(1);
      end else begin
        if (!prevP) lowLen <= runLen;
        runLen <= LW'(1);
      end
    end
  end

  a_r3_complement: assert property (@(posedge clk) disable iff (!rstN)
    clkOutP != clkOutN);

  a_r6_no_runt: assert property (@(posedge clk) disable iff (!rstN)
    (prevP && !clkOutP) |-> (runLen == lowLen));

  a_r1_half_bound: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= MAXH);

  a_r10_role_held: assert property (@(posedge clk) disable iff (!rstN)
    $past(pinOutEn) |-> pinOutEn);

  a_r9_aux_drives_on: assert property (@(posedge clk) disable iff (!rstN)
    pinOutEn |-> clkOutEn);

  always @(negedge clk) begin
    if (!rstN) begin
      a_r4_reset_state: assert (!clkOutP && clkOutN && !pinOutEn);
    end
  end

endmodule

bind bank_clk_out bank_clk_out_chk #(.P_W(P_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkOutP(clkOutP), .clkOutN(clkOutN),
  .clkOutEn(clkOutEn), .pinOutEn(pinOutEn)
);

// File: tb/sim_bank_clk_out.sv
module sim_bank_clk_out;

  logic       clk = 1'b0;
  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pinModeCfg = 2'd1;
  logic       pinIn = 1'b0;
  logic       pinDrv = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrBank = 1'b0;
  logic [5:0] wrData = '0;
  logic       clkOutP, clkOutN, clkOutEn, pinOut, pinOutEn;

  always #5 clk = ~clk;
  always #7 refClk = ~refClk;

  bank_clk_out u0 (
    .clk(clk), .rstN(rstN), .refClk(refClk), .pinModeCfg(pinModeCfg),
    .pinIn(pinIn), .pinDrv(pinDrv), .wrEn(wrEn), .wrBank(wrBank),
    .wrData(wrData), .clkOutP(clkOutP), .clkOutN(clkOutN),
    .clkOutEn(clkOutEn), .pinOut(pinOut), .pinOutEn(pinOutEn)
  );

  int checks = 0;
  int errors = 0;
  int compBad = 0;
  int expQ[$];
  string tagQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: period between rising edges of clkOutP
  int  cyc = 0;
  int  riseCyc = 0;
  bit  haveRise = 0;
  logic lastP = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      haveRise = 0;
      lastP = 1'b0;
    end else begin
      if (clkOutP == clkOutN) compBad++;
      if (clkOutP && !lastP) begin
        if (haveRise && expQ.size() > 0) begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check((cyc - riseCyc) == e, t, cyc - riseCyc, e);
        end
        riseCyc = cyc;
        haveRise = 1;
      end
      lastP = clkOutP;
    end
  end

  // Driver side of the scoreboard
  task automatic pushPeriods(input int p, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(2 * ((p == 0) ? 1 : p));
      tagQ.push_back(tag);
    end
  endtask

  task automatic expectPeriods(input int p, input int n, input string tag);
    repeat (3) @(posedge clkOutP);
    @(negedge clk);
    #1;
    pushPeriods(p, n, tag);
    wait (expQ.size() == 0);
  endtask

  task automatic writeBank(input logic b, input int p, input logic aux);
    @(negedge clk);
    wrEn = 1'b1;
    wrBank = b;
    wrData = {aux, 5'(p)};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic applyReset(input logic [1:0] mode);
    rstN = 1'b0;
    pinModeCfg = mode;
    waitCycles(3);
    check(clkOutP == 1'b0, "R4 clkOutP in reset", clkOutP, 0);
    check(clkOutN == 1'b1, "R4 clkOutN in reset", clkOutN, 1);
    check(pinOutEn == 1'b0, "R4 pinOutEn in reset", pinOutEn, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    // Run 1: bank-select role
    pinDrv = 1'b1;
    pinIn = 1'b0;
    applyReset(2'd1);
    pushPeriods(4, 2, "R4 default period");
    @(negedge clk);
    rstN = 1'b1;
    wait (expQ.size() == 0);

    writeBank(1'b0, 3, 1'b0);
    writeBank(1'b1, 5, 1'b0);
    expectPeriods(3, 3, "R5 new bank0 value");

    pinIn = 1'b1;
    expectPeriods(5, 3, "R6 bank1 selected");

    writeBank(1'b1, 0, 1'b0);
    expectPeriods(0, 3, "R2 zero runs as one");

    writeBank(1'b1, 31, 1'b0);
    expectPeriods(31, 2, "R1 largest value");

    pinIn = 1'b0;
    pinDrv = 1'b0;
    expectPeriods(31, 1, "R8 undriven reads high");

    pinDrv = 1'b1;
    expectPeriods(3, 2, "R6 back to bank0");

    pinModeCfg = 2'd0;
    waitCycles(6);
    check(clkOutEn == 1'b1, "R10 role change ignored", clkOutEn, 1);
    check(pinOutEn == 1'b0, "R9 pin not driven in select role", pinOutEn, 0);
    check(compBad == 0, "R3 complement mismatches", compBad, 0);

    // Run 2: enable role
    pinIn = 1'b1;
    pinDrv = 1'b1;
    applyReset(2'd0);
    @(negedge clk);
    rstN = 1'b1;
    waitCycles(4);
    check(clkOutEn == 1'b1, "R7 enabled on high", clkOutEn, 1);
    pinIn = 1'b0;
    waitCycles(3);
    check(clkOutEn == 1'b0, "R7 tri-state on low", clkOutEn, 0);
    expectPeriods(4, 2, "R7 divider runs while off");
    pinModeCfg = 2'd1;
    pinIn = 1'b1;
    waitCycles(4);
    check(clkOutEn == 1'b1, "R7 re-enabled", clkOutEn, 1);
    pinIn = 1'b0;
    waitCycles(4);
    check(clkOutEn == 1'b0, "R10 enable role held", clkOutEn, 0);
    pinDrv = 1'b0;
    waitCycles(4);
    check(clkOutEn == 1'b1, "R8 undriven enables", clkOutEn, 1);

    // Run 3: auxiliary clock role
    pinDrv = 1'b0;
    applyReset(2'd2);
    @(negedge clk);
    rstN = 1'b1;
    waitCycles(4);
    check(pinOutEn == 1'b1, "R9 pin driven", pinOutEn, 1);
    check(clkOutEn == 1'b1, "R9 main drivers on", clkOutEn, 1);
    @(posedge refClk);
    #1;
    check(pinOut == 1'b1, "R9 pass-through high", pinOut, 1);
    @(negedge refClk);
    #1;
    check(pinOut == 1'b0, "R9 pass-through low", pinOut, 0);
    expectPeriods(4, 1, "R9 bank0 in aux role");

    writeBank(1'b0, 2, 1'b1);
    expectPeriods(2, 2, "R5 bank0 rewritten");
    begin
      int changes = 0;
      logic prevS;
      @(posedge refClk);
      #1;
      prevS = pinOut;
      for (int i = 0; i < 16; i++) begin
        @(posedge refClk);
        #1;
        if (pinOut != prevS) changes++;
        prevS = pinOut;
      end
      check(changes == 16, "R9 halved reference", changes, 16);
    end
    check(compBad == 0, "R3 complement mismatches", compBad, 0);

    summary();
    $finish;
  end

endmodule